// File: doc/BRIEF.md
# Stretchable External Data Bus Sequencer

This block runs one data-memory read or write at a time over a multiplexed address/data bus. It steps through the phases of the access: the low address byte goes out with an address latch strobe, then setup, then an active-low read or write strobe, then hold. It drives the bus output enable for each phase and raises a one-clock done pulse at the end. A machine cycle is four clocks. Every access starts on a machine-cycle boundary. Outside an access the latch strobe pulses once in every machine cycle.

A 3-bit stretch register sets how long an external access is. Software writes it through a load strobe. A stretch of zero gives the fastest access. Each step above zero adds one machine cycle. Any nonzero value also adds one clock of setup and one clock of hold around the strobe, and the strobe widens with it. An access flagged as internal uses the on-chip SRAM timing. It always takes two machine cycles, leaves the external bus alone and does not use the stretch value. Choosing the target and fetching program code are handled outside this block.

Top module: `xbus_stretch_seq`

## Requirements
- R1: A machine cycle is 4 clocks, counted from reset release. Outside external accesses `ale` is high for 1.5 clocks out of every 4: all of phase 0 and the first half of phase 1. `ale` is high during reset. An accepted request starts its access at the next phase-0 clock (clock t=0).
- R2: An external access lasts 4*(2+S) clocks, where S is the stretch value captured for it. `done` is high only in the last clock of the access.
- R3: The stretch register resets to 1, so an external access after reset lasts 12 clocks. A clock with `stretch_we` high loads `stretch_val`. The value is captured when a request is accepted, so a load made during an access only affects later accesses.
- R4: An internal access (`internal`=1) lasts 8 clocks for any stretch value. It never asserts `rd_n` or `wr_n`, never drives the bus, does not suppress `ale`, and leaves `rd_data` unchanged.
- R5: With S=0 the low address is driven at t=0..1, setup is t=2, the strobe is low at t=3..6 (4 clocks) and hold is t=7.
- R6: With S>0 the low address is driven at t=0..1, setup is t=2..3, the strobe is low from t=4 to t=4*(2+S)-3 (4*S+2 clocks) and hold is the last 2 clocks.
- R7: During an external access `ale` pulses only in the first machine cycle (high at t=0 and t=1, sampled early in the clock). It stays low for the rest of the access.
- R8: During an external access `ad_oe` is high and `ad_out` carries the low address byte at t=0..1. For a write, `ad_oe` then stays high with the write data until the access ends. For a read, the bus is released from t=2. `a_hi` carries the high address byte for the whole external access and is 0 otherwise.
- R9: For a read, `rd_data` takes the value of `ad_in` at the clock edge where `rd_n` rises. It is not changed before that edge, and changes on the bus after that edge do not affect it.
- R10: A `start` seen while a request is pending or an access is running (its done clock included) is ignored. The inputs the access uses are captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stretch_we | input | 1 | Loads the stretch register |
| stretch_val | input | 3 | New stretch value |
| start | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| internal | input | 1 | Access targets on-chip SRAM |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| ad_in | input | 8 | Value read back from the multiplexed bus |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_out | output | 8 | Value driven on the multiplexed bus |
| ad_oe | output | 1 | Bus drive enable |
| a_hi | output | 8 | High address byte |
| rd_data | output | 8 | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
External reads and writes are run at stretch 0, 1 (the reset value), 2 and 7. The S=0 case checks the one-clock setup and hold. The nonzero cases check the extra setup and hold clocks and the strobe width, which grows with S. The bus carries the expected byte only during the strobe and a different byte outside it, so early or late capture shows up in `rd_data`. An internal access at stretch 5 is compared against the fixed 8-clock timing. The stretch value is reloaded in the middle of an access, and a second request is issued during an access, to show that the captured values are kept and that extra requests have no effect.

// File: rtl/xbus_stretch_seq.sv
`timescale 1ns/1ps
module xbus_stretch_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 3,
  parameter logic [SW-1:0] RST_STRETCH = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stretch_we,
  input  logic [SW-1:0] stretch_val,
  input  logic          start,
  input  logic          wr,
  input  logic          internal,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  localparam int MC       = 4;
  localparam int PW       = $clog2(MC);
  localparam int ADR_CLKS = 2;
  localparam int TW       = $clog2(MC * ((1 << SW) + 1) + 1);

  logic [PW-1:0] ph;
  logic [SW-1:0] stretch_q, s_q;
  logic          pend, active, wr_q, int_q, ale_neg;
  logic [TW-1:0] t, n_clk, last_t, stb_beg, stb_end;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          ext, nz, in_stb, adr_ph, ale_win;

  assign ext     = active & ~int_q;
  assign nz      = |s_q;
  assign n_clk   = int_q ? TW'(2 * MC) : TW'(MC) * (TW'(2) + TW'(s_q));
  assign last_t  = n_clk - TW'(1);
  assign stb_beg = nz ? TW'(ADR_CLKS + 2) : TW'(ADR_CLKS + 1);
  assign stb_end = nz ? last_t - TW'(2) : last_t - TW'(1);
  assign in_stb  = ext && (t >= stb_beg) && (t <= stb_end);
  assign adr_ph  = ext && (t < TW'(ADR_CLKS));

  assign rd_n   = ~(in_stb & ~wr_q);
  assign wr_n   = ~(in_stb & wr_q);
  assign ad_oe  = adr_ph | (ext & wr_q);
  assign ad_out = !ad_oe ? '0 : (adr_ph ? addr_q[DW-1:0] : wdata_q);
  assign a_hi   = ext ? addr_q[AW-1:DW] : '0;
  assign done   = active && (t == last_t);

  assign ale_win = (ph == '0) && !(ext && (t >= TW'(MC)));
  assign ale     = ~rst_n | ale_win | ale_neg;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) ale_neg <= 1'b0;
    else        ale_neg <= ale_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= '0;
      stretch_q <= RST_STRETCH;
      s_q       <= RST_STRETCH;
      pend      <= 1'b0;
      active    <= 1'b0;
      t         <= '0;
      wr_q      <= 1'b0;
      int_q     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_data   <= '0;
    end else begin
      ph <= ph + PW'(1);
      if (stretch_we) stretch_q <= stretch_val;
      if (start && !pend && !active) begin
        pend    <= 1'b1;
        wr_q    <= wr;
        int_q   <= internal;
        addr_q  <= addr;
        wdata_q <= wdata;
        s_q     <= stretch_q;
      end
      if (pend && ph == PW'(MC - 1)) begin
        pend   <= 1'b0;
        active <= 1'b1;
        t      <= '0;
      end else if (active) begin
        if (t == last_t) active <= 1'b0;
        else             t <= t + TW'(1);
      end
      if (ext && !wr_q && t == stb_end) rd_data <= ad_in;
    end
  end

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r8_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  a_r7_ale_quiet_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !ale);
  a_r4_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active && int_q) |-> (rd_n && wr_n && !ad_oe));
  a_r9_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> rd_data == $past(ad_in));
  a_r3_stretch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(s_q));
endmodule

// File: tb/test_xbus_stretch_seq.sv
`timescale 1ns/1ps
module test_xbus_stretch_seq;
  logic clk = 0, rst_n = 0, stretch_we = 0, start = 0, wr = 0, internal = 0;
  logic [2:0]  stretch_val = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0, ad_in = 0;
  logic ale, rd_n, wr_n, ad_oe, done;
  logic [7:0] ad_out, a_hi, rd_data;
  int total = 0, bad = 0, cyc = 0;
  logic [7:0] last_rd = 0;

  xbus_stretch_seq i_xbus_stretch_seq (
    .clk(clk), .rst_n(rst_n), .stretch_we(stretch_we), .stretch_val(stretch_val),
    .start(start), .wr(wr), .internal(internal), .addr(addr), .wdata(wdata),
    .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .a_hi(a_hi), .rd_data(rd_data), .done(done));

  always #2.5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_stretch(input logic [2:0] v);
    @(negedge clk); stretch_we = 1; stretch_val = v;
    @(negedge clk); stretch_we = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "ale in reset", ale, 1);
    chk("R5", "rd_n in reset", rd_n, 1);
    chk("R5", "wr_n in reset", wr_n, 1);
    chk("R8", "ad_oe in reset", ad_oe, 0);
    chk("R2", "done in reset", done, 0);
    chk("R9", "rd_data in reset", rd_data, 0);
  endtask

  task automatic t_ale_idle;
    do begin @(posedge clk); #1; end while (cyc % 4 != 0);
    for (int k = 0; k < 8; k++) begin
      chk("R1", "ale early", ale, (cyc % 4) < 2);
      #2.5;
      chk("R1", "ale late", ale, (cyc % 4) == 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic run_access(input logic w, input logic intl, input logic [15:0] a,
                            input logic [7:0] d, input logic [7:0] rv, input int s,
                            input int mid_s, input logic poke, input string req);
    int n, sb, se;
    logic ext;
    ext = !intl;
    n  = intl ? 8 : 4 * (2 + s);
    sb = (s == 0) ? 3 : 4;
    se = (s == 0) ? n - 2 : n - 3;
    @(negedge clk);
    while (cyc % 4 != 1) @(negedge clk);
    start = 1; wr = w; internal = intl; addr = a; wdata = d;
    @(negedge clk);
    start = 0; wr = !w; internal = !intl; addr = ~a; wdata = ~d;
    @(posedge clk);
    for (int t = 0; t <= n; t++) begin
      @(posedge clk); #1;
      if (t < n) begin
        chk("R2", "done", done, t == n - 1);
        chk("R7", "ale", ale, ext ? (t < 2) : ((t % 4) < 2));
        chk(req, "rd_n", rd_n, !(ext && !w && t >= sb && t <= se));
        chk(req, "wr_n", wr_n, !(ext && w && t >= sb && t <= se));
        chk("R8", "ad_oe", ad_oe, ext && (t < 2 || w));
        if (ext && (t < 2 || w)) chk("R8", "ad_out", ad_out, t < 2 ? a[7:0] : d);
        chk("R8", "a_hi", a_hi, ext ? a[15:8] : 8'h00);
        if (t == se && ext && !w) chk("R9", "rd_data before capture", rd_data, last_rd);
      end else begin
        chk("R2", "done after end", done, 0);
        chk("R1", "ale back at phase 0", ale, 1);
        chk("R8", "ad_oe after end", ad_oe, 0);
        if (ext && !w) last_rd = rv;
        chk(intl ? "R4" : "R9", "rd_data after access", rd_data, last_rd);
      end
      ad_in = (t >= sb && t <= se) ? rv : ~rv;
      if (mid_s >= 0 && t == 2) begin stretch_we = 1; stretch_val = 3'(mid_s); end
      if (t == 3) stretch_we = 0;
      if (poke && t == 4) begin start = 1; wr = 1; internal = 0; addr = 16'h5A5A; end
      if (poke && t == 5) start = 0;
    end
  endtask

  task automatic t_no_follow;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      chk("R10", "no access after ignored start: rd_n", rd_n, 1);
      chk("R10", "no access after ignored start: wr_n", wr_n, 1);
      chk("R10", "no access after ignored start: ad_oe", ad_oe, 0);
      chk("R10", "no access after ignored start: done", done, 0);
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_ale_idle();
    run_access(0, 0, 16'h12C4, 8'h00, 8'h3C, 1, -1, 0, "R3");
    run_access(1, 0, 16'hA7E1, 8'h96, 8'h00, 1, -1, 0, "R6");
    set_stretch(0);
    run_access(1, 0, 16'h0455, 8'hD2, 8'h00, 0, -1, 0, "R5");
    run_access(0, 0, 16'hFF01, 8'h00, 8'hB7, 0, -1, 0, "R5");
    set_stretch(7);
    run_access(0, 0, 16'h8008, 8'h00, 8'h6E, 7, 2, 0, "R6");
    run_access(0, 0, 16'h3412, 8'h00, 8'h81, 2, -1, 0, "R3");
    set_stretch(5);
    run_access(0, 1, 16'h0100, 8'h00, 8'hEE, 5, -1, 0, "R4");
    run_access(1, 1, 16'h0200, 8'h44, 8'h00, 5, -1, 0, "R4");
    set_stretch(1);
    run_access(0, 0, 16'h7711, 8'h00, 8'h29, 1, -1, 1, "R10");
    t_no_follow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule